// File: doc/BRIEF.md
# Branch Category Classifier

This block sorts one recorded control-flow change into a category. It takes the leading opcode bytes of the source instruction, already aligned, together with the instruction's ModRM byte. It also takes the privilege level (user or kernel) of the source and of the destination, and two flags that mark a zero source or destination address. It returns a 12-bit vector. One bit in that vector names the kind of transfer, and one bit names the privilege of the target.

A branch-record filter presents each recorded entry with `in_valid`. The category appears on `br_class` one clock later, or two clocks later when `IN_REG` is 1, and `out_valid` marks that cycle. A user-to-kernel transfer whose source instruction is not a system-call entry or a software interrupt must have been caused by an asynchronous event. The block reports such a transfer as a hardware interrupt/trap.

Top module: `branch_classifier`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `br_class` is all zeros.
- R2: A result appears on `br_class` with `out_valid` high exactly one cycle after `in_valid` (default `IN_REG`=0). When no result is due, `out_valid` is 0 and `br_class` keeps its last value.
- R3: When `op0` is 0x0F, the second byte decides the category: 0x05 or 0x34 gives syscall (bit 4); 0x07 or 0x35 gives sysret (bit 5); 0x80..0x8F gives conditional (bit 8); any other value gives no category.
- R4: These one-byte opcodes give the following categories: 0x70..0x7F and 0xE0..0xE3 give conditional (bit 8); 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3); 0xCF gives iret (bit 7); 0xCC..0xCE give software interrupt (bit 6).
- R5: 0xE8 and 0x9A give call (bit 2). 0xE9..0xEB give jump (bit 9).
- R6: For 0xFF, ModRM bits 5:3 decide the category: 2 or 3 give indirect call (bit 11); 4 or 5 give jump (bit 9); any other value gives no category.
- R7: If the source address or the destination address is zero, the whole result is 0, and this takes precedence over every other rule.
- R8: A transfer from a user source to a kernel destination is reported as hardware interrupt/trap (bit 10) whenever the decoded category is neither syscall nor software interrupt. This includes an unrecognised opcode.
- R9: When the category is not none, the target privilege is added: bit 0 for a user target, bit 1 for a kernel target. When the category is none, both bits are 0.
- R10: An unrecognised opcode yields 0, unless R8 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch entry is presented this cycle |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second opcode byte (used after 0x0F) |
| modrm | input | 8 | ModRM byte (used after 0xFF) |
| src_kernel | input | 1 | Source is kernel (0 = user) |
| dst_kernel | input | 1 | Destination is kernel (0 = user) |
| src_zero | input | 1 | Source address is zero |
| dst_zero | input | 1 | Destination address is zero |
| out_valid | output | 1 | `br_class` holds a fresh result |
| br_class | output | 12 | One-hot category in bits 11:2 plus target privilege in bits 1:0 |

## Verification
Each result is due one clock after its entry is presented, because the only register on the path is the output stage. The driver therefore applies an entry on a falling edge. The result is then registered on the next rising edge and compared on the falling edge after that, where the monitor pops the expected value queued by the driver. On falling edges with no pending result, the monitor checks that `out_valid` is low and that `br_class` still holds the previous value. At the end it confirms that the queue has drained.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int BYTE_W = 8;
  localparam int NTYPE  = 10;
  localparam int PRIV_W = 2;
  localparam int CLS_W  = NTYPE + PRIV_W;

  // category positions inside the type field (class bit = index + PRIV_W)
  localparam int T_CALL  = 0;
  localparam int T_RET   = 1;
  localparam int T_SYSC  = 2;
  localparam int T_SYSR  = 3;
  localparam int T_SWINT = 4;
  localparam int T_IRET  = 5;
  localparam int T_COND  = 6;
  localparam int T_JUMP  = 7;
  localparam int T_IRQ   = 8;
  localparam int T_ICALL = 9;

  localparam int P_USER = 0;
  localparam int P_KERN = 1;

  typedef logic [NTYPE-1:0] type_t;
  typedef logic [CLS_W-1:0] cls_t;

  typedef struct packed {
    logic [BYTE_W-1:0] b0;
    logic [BYTE_W-1:0] b1;
    logic [BYTE_W-1:0] mrm;
    logic              skern;
    logic              dkern;
    logic              szero;
    logic              dzero;
  } entry_t;
endpackage

// File: rtl/brc_opdecode.sv
module brc_opdecode
  import brc_pkg::*;
(
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] mrm,
  output type_t             kind
);
  localparam int REG_LO = 3;
  localparam int REG_HI = 5;

  logic [REG_HI-REG_LO:0] regf;
  assign regf = mrm[REG_HI:REG_LO];

  always_comb begin
    kind = '0;
    unique casez (b0)
      8'h0F: begin
        unique casez (b1)
          8'h05, 8'h34: kind[T_SYSC] = 1'b1;
          8'h07, 8'h35: kind[T_SYSR] = 1'b1;
          8'b1000_????: kind[T_COND] = 1'b1;
          default:      kind = '0;
        endcase
      end
      8'b0111_????:               kind[T_COND]  = 1'b1;
      8'hE0, 8'hE1, 8'hE2, 8'hE3: kind[T_COND]  = 1'b1;
      8'hC2, 8'hC3, 8'hCA, 8'hCB: kind[T_RET]   = 1'b1;
      8'hCF:                      kind[T_IRET]  = 1'b1;
      8'hCC, 8'hCD, 8'hCE:        kind[T_SWINT] = 1'b1;
      8'hE8, 8'h9A:               kind[T_CALL]  = 1'b1;
      8'hE9, 8'hEA, 8'hEB:        kind[T_JUMP]  = 1'b1;
      8'hFF: begin
        unique case (regf)
          3'd2, 3'd3: kind[T_ICALL] = 1'b1;
          3'd4, 3'd5: kind[T_JUMP]  = 1'b1;
          default:    kind = '0;
        endcase
      end
      default: kind = '0;
    endcase
  end
endmodule

// File: rtl/brc_ringfix.sv
module brc_ringfix
  import brc_pkg::*;
(
  input  type_t kind,
  input  logic  skern,
  input  logic  dkern,
  input  logic  szero,
  input  logic  dzero,
  output cls_t  cls
);
  type_t fixed;
  logic  async_entry;

  // user -> kernel not caused by a ring-entry instruction
  assign async_entry = !skern && dkern && !kind[T_SYSC] && !kind[T_SWINT];

  always_comb begin
    fixed = kind;
    if (async_entry) begin
      fixed = '0;
      fixed[T_IRQ] = 1'b1;
    end
    cls = '0;
    if (!szero && !dzero && (fixed != '0)) begin
      cls[CLS_W-1:PRIV_W] = fixed;
      cls[P_USER] = !dkern;
      cls[P_KERN] = dkern;
    end
  end
endmodule

// File: rtl/branch_classifier.sv
module branch_classifier
  import brc_pkg::*;
#(
  parameter bit IN_REG = 1'b0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] op0,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] modrm,
  input  logic              src_kernel,
  input  logic              dst_kernel,
  input  logic              src_zero,
  input  logic              dst_zero,
  output logic              out_valid,
  output logic [CLS_W-1:0]  br_class
);
  entry_t raw, s_ent;
  logic   s_valid;
  type_t  kind;
  cls_t   cls_next;

  assign raw = '{b0: op0, b1: op1, mrm: modrm, skern: src_kernel,
                 dkern: dst_kernel, szero: src_zero, dzero: dst_zero};

  generate
    if (IN_REG) begin : g_inreg
      always_ff @(posedge clk) begin
        if (rst) begin
          s_valid <= 1'b0;
          s_ent   <= '0;
        end else begin
          s_valid <= in_valid;
          if (in_valid) s_ent <= raw;
        end
      end
    end else begin : g_direct
      assign s_valid = in_valid;
      assign s_ent   = raw;
    end
  endgenerate

  brc_opdecode u_dec (
    .b0   (s_ent.b0),
    .b1   (s_ent.b1),
    .mrm  (s_ent.mrm),
    .kind (kind)
  );

  brc_ringfix u_fix (
    .kind  (kind),
    .skern (s_ent.skern),
    .dkern (s_ent.dkern),
    .szero (s_ent.szero),
    .dzero (s_ent.dzero),
    .cls   (cls_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      br_class  <= '0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) br_class <= cls_next;
    end
  end

  // R2: a presented entry yields a result on the next cycle
  a_r2_result_next: assert property (@(posedge clk) disable iff (rst)
    s_valid |=> out_valid);

  // R2: no entry, no result, class held
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> (!out_valid && $stable(br_class)));

  // R7: zero address clears everything
  a_r7_zero_addr: assert property (@(posedge clk) disable iff (rst)
    (s_valid && (s_ent.szero || s_ent.dzero)) |=> (br_class == '0));

  // R8: asynchronous entry becomes irq
  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_ent.szero && !s_ent.dzero && !s_ent.skern && s_ent.dkern
     && !kind[T_SYSC] && !kind[T_SWINT]) |=> br_class[T_IRQ+PRIV_W]);

  // R3..R6: at most one category
  a_r4_onecat: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(br_class[CLS_W-1:PRIV_W]));

  // R9: privilege present exactly when a category is present
  a_r9_priv: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((br_class[CLS_W-1:PRIV_W] != '0) ?
                   ($countones(br_class[PRIV_W-1:0]) == 1) :
                   (br_class[PRIV_W-1:0] == '0)));
endmodule

// File: tb/branch_classifier_test.sv
module branch_classifier_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op0 = '0, op1 = '0, modrm = '0;
  logic        src_kernel = 1'b0, dst_kernel = 1'b0;
  logic        src_zero = 1'b0, dst_zero = 1'b0;
  logic        out_valid;
  logic [11:0] br_class;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit active = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] last_cls = '0;

  always #2.5 clk = ~clk;

  branch_classifier uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op0(op0), .op1(op1),
    .modrm(modrm), .src_kernel(src_kernel), .dst_kernel(dst_kernel),
    .src_zero(src_zero), .dst_zero(dst_zero),
    .out_valid(out_valid), .br_class(br_class)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  // driver: present one entry on a falling edge, queue its expectation
  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                      input logic sk, input logic dk, input logic sz, input logic dz,
                      input logic [11:0] exp, input string tag);
    op0 = a; op1 = b; modrm = m;
    src_kernel = sk; dst_kernel = dk; src_zero = sz; dst_zero = dz;
    in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: results are due one cycle after the entry
  always @(negedge clk) begin
    if (active) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected result", br_class, 12'hFFF);
        end else begin
          logic [11:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, br_class, e);
          last_cls = br_class;
        end
      end else begin
        check("R2 hold while idle", br_class, last_cls);
      end
    end
  end

  localparam logic [11:0] U = 12'h001, K = 12'h002;
  localparam logic [11:0] CALL = 12'h004, RET = 12'h008, SYSC = 12'h010, SYSR = 12'h020;
  localparam logic [11:0] SWI = 12'h040, IRET = 12'h080, COND = 12'h100, JMP = 12'h200;
  localparam logic [11:0] IRQ = 12'h400, ICALL = 12'h800;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {11'd0, out_valid}, 12'h000);
    check("R1 reset class", br_class, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    active = 1'b1;
    // R3 two-byte forms
    send(8'h0F, 8'h05, 8'h00, 0, 1, 0, 0, SYSC | K, "R3 0F05 u->k");
    send(8'h0F, 8'h34, 8'h00, 1, 1, 0, 0, SYSC | K, "R3 0F34");
    send(8'h0F, 8'h07, 8'h00, 1, 0, 0, 0, SYSR | U, "R3 0F07");
    send(8'h0F, 8'h35, 8'h00, 1, 0, 0, 0, SYSR | U, "R3 0F35");
    send(8'h0F, 8'h85, 8'h00, 0, 0, 0, 0, COND | U, "R3 0F85");
    send(8'h0F, 8'h8F, 8'h00, 1, 1, 0, 0, COND | K, "R3 0F8F");
    send(8'h0F, 8'h90, 8'h00, 1, 1, 0, 0, 12'h000, "R3 0F90 none");
    // R4 one-byte forms
    send(8'h74, 8'h00, 8'h00, 0, 0, 0, 0, COND | U, "R4 74");
    repeat (2) @(negedge clk);
    send(8'hE2, 8'h00, 8'h00, 1, 1, 0, 0, COND | K, "R4 E2 loop");
    send(8'hC3, 8'h00, 8'h00, 1, 0, 0, 0, RET | U, "R4 C3");
    send(8'hCA, 8'h00, 8'h00, 0, 0, 0, 0, RET | U, "R4 CA");
    send(8'hCF, 8'h00, 8'h00, 1, 0, 0, 0, IRET | U, "R4 CF");
    send(8'hCD, 8'h00, 8'h00, 0, 1, 0, 0, SWI | K, "R4 CD u->k");
    // R5
    send(8'hE8, 8'h00, 8'h00, 0, 0, 0, 0, CALL | U, "R5 E8");
    send(8'h9A, 8'h00, 8'h00, 1, 1, 0, 0, CALL | K, "R5 9A");
    send(8'hEB, 8'h00, 8'h00, 0, 0, 0, 0, JMP | U, "R5 EB");
    send(8'hE9, 8'h00, 8'h00, 1, 1, 0, 0, JMP | K, "R5 E9");
    // R6 ModRM reg field
    send(8'hFF, 8'h00, 8'h10, 0, 0, 0, 0, ICALL | U, "R6 FF /2");
    send(8'hFF, 8'h00, 8'h1D, 1, 1, 0, 0, ICALL | K, "R6 FF /3");
    send(8'hFF, 8'h00, 8'h20, 0, 0, 0, 0, JMP | U, "R6 FF /4");
    send(8'hFF, 8'h00, 8'h2F, 0, 0, 0, 0, JMP | U, "R6 FF /5");
    send(8'hFF, 8'h00, 8'h08, 0, 0, 0, 0, 12'h000, "R6 FF /1 none");
    // R7
    send(8'hE8, 8'h00, 8'h00, 0, 0, 1, 0, 12'h000, "R7 src zero");
    send(8'hC3, 8'h00, 8'h00, 0, 1, 0, 1, 12'h000, "R7 dst zero u->k");
    // R8
    send(8'hC3, 8'h00, 8'h00, 0, 1, 0, 0, IRQ | K, "R8 ret u->k");
    send(8'h90, 8'h00, 8'h00, 0, 1, 0, 0, IRQ | K, "R8 unknown u->k");
    // R9 / R10
    send(8'h74, 8'h00, 8'h00, 1, 0, 0, 0, COND | U, "R9 k->u target user");
    send(8'h90, 8'h00, 8'h00, 0, 0, 0, 0, 12'h000, "R10 unknown");
    send(8'h90, 8'h00, 8'h00, 1, 0, 0, 0, 12'h000, "R10 unknown k->u");
    repeat (4) @(negedge clk);
    check("R2 queue drained", 12'(exp_q.size()), 12'h000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule